// File: doc/BRIEF.md
# Serial Converter Command Sequencer

This block is the digital control core of a serially controlled 10-bit sampling converter. A host frames each access with an active-low chip select. While the frame is open, the host shifts a 4-bit command in on the rising edges of a serial clock. On the falling edges of the same clock, the block shifts the previous conversion result out. When chip select rises, the command is decoded. It can start a conversion on one of eight channels, set the conversion speed to fast or slow, or send the block into a low-power standby state.

The sequencer counts the conversion time itself, in clock cycles, using a fast count or a slow count picked by a rate register. An end-of-conversion line falls while a conversion runs. A one-cycle start pulse and a channel number go to the converter model, and its data word is captured when the count expires. The speed must be programmed once after reset before any conversion is accepted. A status line shows that this has not yet happened. Standby ends at the next falling edge of chip select and leaves the rate setting untouched. The first result after reset, and the first result after standby ends, are tagged as not valid.

Top module: `adc_ctl_seq`

## Requirements
- R1: After reset, `eoc` is 1, `rate_unset` is 1, `pwr_down` is 0, `res_valid` is 0, `sdo_oe` is 0 and the stored result is 0.
- R2: A command is captured MSB first, one bit on each rising `sclk` edge while `cs_n` is low. It takes effect on the rising edge of `cs_n` only if at least 4 rising `sclk` edges occurred since `cs_n` last fell. A shorter frame has no effect, and a new falling edge of `cs_n` restarts capture.
- R3: Command 9h sets `rate_fast` to 1 and command Ah sets it to 0. Either one clears `rate_unset`, which stays 0 until the next reset.
- R4: A command 0h to 7h, with the rate programmed and no conversion running, produces a one-cycle `conv_start` pulse with `conv_chan` equal to the command's low three bits. After that, `eoc` is low for exactly FAST_CYC cycles (rate fast) or SLOW_CYC cycles (rate slow), and `conv_data` is captured as the result.
- R5: A conversion command received while `rate_unset` is 1 is ignored: no `conv_start` pulse, and `eoc` stays 1.
- R6: Command 8h sets `pwr_down`. The next falling edge of `cs_n` clears it, even if the frame is then aborted. `rate_fast` is unchanged across standby and wake-up.
- R7: The first conversion completing after reset has `res_valid` 0. Later conversions have `res_valid` 1.
- R8: The first conversion completing after leaving standby has `res_valid` 0.
- R9: `sdo` presents the stored result MSB first. The MSB appears once `cs_n` is low, and the next bit follows each falling `sclk` edge. `sdo_oe` is 1 exactly while `cs_n` is low, and `sdo` is high impedance otherwise.
- R10: A frame that ends while `eoc` is 0 is ignored: it changes neither the rate nor the standby state.
- R11: Commands Bh to Fh have no effect on rate, standby or conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low frame select |
| sclk | input | 1 | Serial shift clock |
| sdi | input | 1 | Serial command data |
| sdo | output | 1 | Serial result data, high impedance when not selected |
| sdo_oe | output | 1 | Output drive enable for `sdo` |
| eoc | output | 1 | High when no conversion is running |
| conv_start | output | 1 | One-cycle pulse to the converter model |
| conv_chan | output | 3 | Channel of the conversion being started |
| conv_data | input | 10 | Data word from the converter model |
| res_valid | output | 1 | Stored result is trustworthy |
| rate_fast | output | 1 | Current conversion rate, 1 for fast |
| pwr_down | output | 1 | Standby state |
| rate_unset | output | 1 | Rate not yet programmed since reset |

## Verification
The hardest state to reach from the ports is a command frame that lands while a conversion is still counting. The bench gets there by setting the slow rate, so the conversion window is longer than two short 4-clock frames. It launches a conversion without waiting for it, then sends a fast-rate command and a standby command back to back inside that window. The ignored frames are confirmed through the measured length of the `eoc` low window and through `rate_fast` and `pwr_down` afterwards. The validity tag after standby is reached by a wake-up frame with no clocks, followed by two conversions whose flags differ.

// File: rtl/adc_ctl_pkg.sv
`timescale 1ns/1ps
package adc_ctl_pkg;

    localparam int CMD_W  = 4;
    localparam int CHAN_W = CMD_W - 1;

    localparam logic [CMD_W-1:0] NIB_SLEEP = 4'h8;
    localparam logic [CMD_W-1:0] NIB_FAST  = 4'h9;
    localparam logic [CMD_W-1:0] NIB_SLOW  = 4'hA;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_CONV  = 2'd1,
        OP_RATE  = 2'd2,
        OP_SLEEP = 2'd3
    } op_e;

    typedef struct packed {
        op_e               op;
        logic              fast;
        logic [CHAN_W-1:0] chan;
    } cmd_t;

    // Nibbles with the top bit clear request a conversion on the channel
    // given by the remaining bits; a few top-bit-set codes are control.
    function automatic cmd_t decode_nib(input logic [CMD_W-1:0] nib);
        cmd_t c;
        c.op   = OP_NONE;
        c.fast = 1'b0;
        c.chan = nib[CHAN_W-1:0];
        if (!nib[CMD_W-1])
            c.op = OP_CONV;
        else if (nib == NIB_SLEEP)
            c.op = OP_SLEEP;
        else if (nib == NIB_FAST) begin
            c.op   = OP_RATE;
            c.fast = 1'b1;
        end
        else if (nib == NIB_SLOW)
            c.op = OP_RATE;
        return c;
    endfunction

endpackage

// File: rtl/adc_ser_port.sv
`timescale 1ns/1ps
module adc_ser_port
    import adc_ctl_pkg::*;
#(
    parameter int DATA_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              sdi,
    input  logic [DATA_W-1:0] load_val,
    output logic              frame_open,
    output logic              frame_close,
    output logic [CMD_W-1:0]  nib,
    output logic              nib_full,
    output logic              sdo_bit,
    output logic              sdo_oe
);
    localparam int CNT_W = $clog2(CMD_W + 1);

    logic              cs_q;
    logic              sclk_q;
    logic [CMD_W-1:0]  in_sr;
    logic [CNT_W-1:0]  bit_cnt;
    logic [DATA_W-1:0] out_sr;
    logic              sclk_rise;
    logic              sclk_fall;

    assign frame_open  = cs_q & ~cs_n;
    assign frame_close = ~cs_q & cs_n;
    assign sclk_rise   = ~sclk_q & sclk & ~cs_n;
    assign sclk_fall   = sclk_q & ~sclk & ~cs_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_q    <= 1'b1;
            sclk_q  <= 1'b0;
            in_sr   <= '0;
            bit_cnt <= '0;
            out_sr  <= '0;
        end else begin
            cs_q   <= cs_n;
            sclk_q <= sclk;
            if (cs_n) begin
                // idle: keep the outgoing word current so its MSB is ready
                out_sr <= load_val;
            end else if (frame_open) begin
                in_sr   <= '0;
                bit_cnt <= '0;
            end else begin
                if (sclk_rise && bit_cnt < CNT_W'(CMD_W)) begin
                    in_sr   <= {in_sr[CMD_W-2:0], sdi};
                    bit_cnt <= bit_cnt + 1'b1;
                end
                if (sclk_fall)
                    out_sr <= {out_sr[DATA_W-2:0], 1'b0};
            end
        end
    end

    assign nib      = in_sr;
    assign nib_full = (bit_cnt == CNT_W'(CMD_W));
    assign sdo_bit  = out_sr[DATA_W-1];
    assign sdo_oe   = ~cs_n;

endmodule

// File: rtl/adc_cmd_ctrl.sv
`timescale 1ns/1ps
module adc_cmd_ctrl
    import adc_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_open,
    input  logic              frame_close,
    input  logic [CMD_W-1:0]  nib,
    input  logic              nib_full,
    input  logic              busy,
    input  logic              conv_done,
    output logic              rate_fast,
    output logic              rate_unset,
    output logic              pwr_down,
    output logic              discard,
    output logic              conv_req,
    output logic [CHAN_W-1:0] conv_chan
);
    cmd_t cmd;
    logic accept;

    assign cmd    = decode_nib(nib);
    assign accept = frame_close & nib_full & ~busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            rate_fast  <= 1'b0;
            rate_unset <= 1'b1;
            pwr_down   <= 1'b0;
            discard    <= 1'b1;
            conv_req   <= 1'b0;
            conv_chan  <= '0;
        end else begin
            conv_req <= 1'b0;
            if (conv_done)
                discard <= 1'b0;
            if (frame_open && pwr_down) begin
                pwr_down <= 1'b0;
                discard  <= 1'b1;
            end
            if (accept) begin
                case (cmd.op)
                    OP_RATE: begin
                        rate_fast  <= cmd.fast;
                        rate_unset <= 1'b0;
                    end
                    OP_SLEEP: pwr_down <= 1'b1;
                    OP_CONV: begin
                        if (!rate_unset) begin
                            conv_req  <= 1'b1;
                            conv_chan <= cmd.chan;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/adc_conv_timer.sv
`timescale 1ns/1ps
module adc_conv_timer #(
    parameter int DATA_W   = 10,
    parameter int FAST_CYC = 48,
    parameter int SLOW_CYC = 104
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              conv_req,
    input  logic              rate_fast,
    input  logic              discard,
    input  logic [DATA_W-1:0] conv_data,
    output logic              busy,
    output logic              conv_done,
    output logic [DATA_W-1:0] result,
    output logic              res_valid
);
    localparam int MAX_CYC = (FAST_CYC > SLOW_CYC) ? FAST_CYC : SLOW_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);
    localparam logic [CNT_W-1:0] FAST_LD = CNT_W'(FAST_CYC - 1);
    localparam logic [CNT_W-1:0] SLOW_LD = CNT_W'(SLOW_CYC - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy      <= 1'b0;
            cnt       <= '0;
            conv_done <= 1'b0;
            result    <= '0;
            res_valid <= 1'b0;
        end else begin
            conv_done <= 1'b0;
            if (!busy) begin
                if (conv_req) begin
                    busy <= 1'b1;
                    cnt  <= rate_fast ? FAST_LD : SLOW_LD;
                end
            end else if (cnt == '0) begin
                busy      <= 1'b0;
                conv_done <= 1'b1;
                result    <= conv_data;
                res_valid <= ~discard;
            end else begin
                cnt <= cnt - 1'b1;
            end
        end
    end

endmodule

// File: rtl/adc_ctl_seq.sv
`timescale 1ns/1ps
module adc_ctl_seq
    import adc_ctl_pkg::*;
#(
    parameter int DATA_W   = 10,
    parameter int FAST_CYC = 48,
    parameter int SLOW_CYC = 104
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              sdi,
    output logic              sdo,
    output logic              sdo_oe,
    output logic              eoc,
    output logic              conv_start,
    output logic [CHAN_W-1:0] conv_chan,
    input  logic [DATA_W-1:0] conv_data,
    output logic              res_valid,
    output logic              rate_fast,
    output logic              pwr_down,
    output logic              rate_unset
);
    logic              frame_open;
    logic              frame_close;
    logic [CMD_W-1:0]  nib;
    logic              nib_full;
    logic              sdo_bit;
    logic              busy;
    logic              conv_done;
    logic              discard;
    logic              conv_req;
    logic [DATA_W-1:0] result;

    adc_ser_port #(.DATA_W(DATA_W)) u_port (
        .clk         (clk),
        .rst         (rst),
        .cs_n        (cs_n),
        .sclk        (sclk),
        .sdi         (sdi),
        .load_val    (result),
        .frame_open  (frame_open),
        .frame_close (frame_close),
        .nib         (nib),
        .nib_full    (nib_full),
        .sdo_bit     (sdo_bit),
        .sdo_oe      (sdo_oe)
    );

    adc_cmd_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .frame_open  (frame_open),
        .frame_close (frame_close),
        .nib         (nib),
        .nib_full    (nib_full),
        .busy        (busy),
        .conv_done   (conv_done),
        .rate_fast   (rate_fast),
        .rate_unset  (rate_unset),
        .pwr_down    (pwr_down),
        .discard     (discard),
        .conv_req    (conv_req),
        .conv_chan   (conv_chan)
    );

    adc_conv_timer #(
        .DATA_W   (DATA_W),
        .FAST_CYC (FAST_CYC),
        .SLOW_CYC (SLOW_CYC)
    ) u_timer (
        .clk       (clk),
        .rst       (rst),
        .conv_req  (conv_req),
        .rate_fast (rate_fast),
        .discard   (discard),
        .conv_data (conv_data),
        .busy      (busy),
        .conv_done (conv_done),
        .result    (result),
        .res_valid (res_valid)
    );

    assign eoc        = ~busy;
    assign conv_start = conv_req;
    assign sdo        = sdo_oe ? sdo_bit : 1'bz;

endmodule

// File: rtl/adc_ctl_seq_chk.sv
`timescale 1ns/1ps
module adc_ctl_seq_chk (
    input logic clk,
    input logic rst,
    input logic cs_n,
    input logic eoc,
    input logic conv_start,
    input logic rate_fast,
    input logic pwr_down,
    input logic rate_unset
);
    // R4: a start pulse is followed by eoc low
    p_start_busy_r4: assert property (@(posedge clk) disable iff (rst)
        conv_start |=> !eoc);

    // R4: eoc only falls right after a start pulse
    p_eoc_fall_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(eoc) |-> $past(conv_start));

    // R5: no start before the rate has been programmed
    p_start_rate_r5: assert property (@(posedge clk) disable iff (rst)
        conv_start |-> !rate_unset);

    // R3: once programmed, the rate stays programmed
    p_rate_sticky_r3: assert property (@(posedge clk) disable iff (rst)
        !rate_unset |=> !rate_unset);

    // R6: rate is held while in standby
    p_rate_hold_r6: assert property (@(posedge clk) disable iff (rst)
        $past(pwr_down) |-> rate_fast == $past(rate_fast));

    // R6: standby ends only with chip select low
    p_wake_cs_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(pwr_down) |-> !cs_n);

    // R6: no conversion runs in standby
    p_pd_idle_r6: assert property (@(posedge clk) disable iff (rst)
        pwr_down |-> eoc);
endmodule

bind adc_ctl_seq adc_ctl_seq_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .cs_n       (cs_n),
    .eoc        (eoc),
    .conv_start (conv_start),
    .rate_fast  (rate_fast),
    .pwr_down   (pwr_down),
    .rate_unset (rate_unset)
);

// File: tb/adc_ctl_seq_bench.sv
`timescale 1ns/1ps
module adc_ctl_seq_bench;
    localparam int FAST_N = 48;
    localparam int SLOW_N = 104;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_n = 1'b1;
    logic       sclk = 1'b0;
    logic       sdi = 1'b0;
    logic [9:0] conv_data = '0;
    wire        sdo;
    logic       sdo_oe, eoc, conv_start, res_valid, rate_fast, pwr_down, rate_unset;
    logic [2:0] conv_chan;

    int tests = 0;
    int fails = 0;
    int starts = 0;
    int issued = 0;
    int done_cnt = 0;
    logic oe_in_frame;

    typedef struct {
        logic [2:0] chan;
        logic       valid;
        int         ncyc;
        string      tag;
    } exp_t;
    exp_t exp_q[$];

    always #5 clk = ~clk;

    adc_ctl_seq u_adc_ctl_seq (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
        .sdo(sdo), .sdo_oe(sdo_oe), .eoc(eoc), .conv_start(conv_start),
        .conv_chan(conv_chan), .conv_data(conv_data), .res_valid(res_valid),
        .rate_fast(rate_fast), .pwr_down(pwr_down), .rate_unset(rate_unset)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("[TB] FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic frame(input logic [3:0] nib, input int nclk, output logic [9:0] rd);
        rd = '0;
        @(negedge clk); cs_n = 1'b0;
        repeat (2) @(negedge clk);
        oe_in_frame = sdo_oe;
        for (int i = 0; i < nclk; i++) begin
            sdi = (i < 4) ? nib[3-i] : 1'b0;
            repeat (3) @(negedge clk); sclk = 1'b1;
            repeat (3) @(negedge clk);
            if (i < 10) rd[9-i] = sdo;
            sclk = 1'b0;
        end
        repeat (2) @(negedge clk); cs_n = 1'b1; sdi = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic conv(input logic [3:0] nib, input logic [9:0] data, input logic vld,
                        input int ncyc, input string tag, input bit wait_done);
        exp_t it;
        logic [9:0] rd;
        it.chan = nib[2:0]; it.valid = vld; it.ncyc = ncyc; it.tag = tag;
        conv_data = data;
        exp_q.push_back(it);
        issued++;
        frame(nib, 10, rd);
        if (wait_done) begin
            wait (done_cnt == issued);
            @(negedge clk);
        end
    endtask

    // monitor: pops expected items as conversions start and finish
    initial begin
        exp_t it;
        int cyc;
        wait (rst == 1'b0);
        forever begin
            @(negedge clk);
            if (conv_start) begin
                starts++;
                if (exp_q.size() == 0) begin
                    tests++; fails++;
                    $display("[TB] FAIL R4: actual unexpected start expected none");
                end else begin
                    it = exp_q.pop_front();
                    chk("R4 conv_chan", 32'(conv_chan), 32'(it.chan));
                    cyc = 0;
                    @(negedge clk);
                    while (!eoc) begin
                        cyc++;
                        @(negedge clk);
                    end
                    chk("R4 eoc low cycles", 32'(cyc), 32'(it.ncyc));
                    chk(it.tag, 32'(res_valid), 32'(it.valid));
                end
                done_cnt++;
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        tests++; fails++;
        $display("[TB] FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [9:0] rd;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 eoc", 32'(eoc), 1);
        chk("R1 rate_unset", 32'(rate_unset), 1);
        chk("R1 pwr_down", 32'(pwr_down), 0);
        chk("R1 res_valid", 32'(res_valid), 0);
        chk("R1 sdo_oe idle", 32'(sdo_oe), 0);

        // R5 conversion before rate programming is ignored
        frame(4'h3, 10, rd);
        chk("R1 stored result zero", 32'(rd), 0);
        chk("R9 sdo_oe in frame", 32'(oe_in_frame), 1);
        repeat (SLOW_N + 5) @(negedge clk);
        chk("R5 no start", 32'(starts), 0);
        chk("R5 eoc high", 32'(eoc), 1);

        // R2 short frame aborted
        frame(4'h9, 2, rd);
        chk("R2 short frame ignored", 32'(rate_unset), 1);
        // R11 unused code
        frame(4'hC, 10, rd);
        chk("R11 Ch no effect", 32'(rate_unset), 1);
        chk("R9 sdo_oe after frame", 32'(sdo_oe), 0);

        // R3 fast rate
        frame(4'h9, 10, rd);
        chk("R3 fast selected", 32'(rate_fast), 1);
        chk("R3 rate_unset cleared", 32'(rate_unset), 0);

        // R7 first result after reset is invalid
        conv(4'h5, 10'h2A5, 1'b0, FAST_N, "R7 first result invalid", 1'b1);
        frame(4'hB, 10, rd);
        chk("R9 readback 2A5", 32'(rd), 32'h2A5);
        chk("R11 Bh rate kept", 32'(rate_fast), 1);
        chk("R4 start count", 32'(starts), 1);
        conv(4'h2, 10'h3C3, 1'b1, FAST_N, "R7 later result valid", 1'b1);
        frame(4'hB, 10, rd);
        chk("R9 readback 3C3", 32'(rd), 32'h3C3);

        // R3 slow rate
        frame(4'hA, 10, rd);
        chk("R3 slow selected", 32'(rate_fast), 0);
        conv(4'h7, 10'h155, 1'b1, SLOW_N, "R7 slow result valid", 1'b1);

        // R10 frames during a conversion are ignored
        conv(4'h1, 10'h0F0, 1'b1, SLOW_N, "R10 result valid", 1'b0);
        chk("R10 busy during frames", 32'(eoc), 0);
        frame(4'h9, 4, rd);
        frame(4'h8, 4, rd);
        wait (done_cnt == issued);
        @(negedge clk);
        chk("R10 rate unchanged", 32'(rate_fast), 0);
        chk("R10 no standby", 32'(pwr_down), 0);

        // R6 standby and wake on chip select
        frame(4'h8, 4, rd);
        chk("R6 standby entered", 32'(pwr_down), 1);
        @(negedge clk); cs_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R6 wake on cs low", 32'(pwr_down), 0);
        cs_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R6 slow rate kept", 32'(rate_fast), 0);

        // R8 first result after wake invalid
        conv(4'h6, 10'h3FF, 1'b0, SLOW_N, "R8 first after wake invalid", 1'b1);
        conv(4'h4, 10'h001, 1'b1, SLOW_N, "R8 second after wake valid", 1'b1);
        frame(4'hE, 10, rd);
        chk("R9 readback 001", 32'(rd), 32'h001);

        // R6 fast rate kept across standby
        frame(4'h9, 10, rd);
        frame(4'h8, 10, rd);
        chk("R6 standby again", 32'(pwr_down), 1);
        frame(4'hF, 10, rd);
        chk("R6 woke by frame", 32'(pwr_down), 0);
        chk("R6 fast rate kept", 32'(rate_fast), 1);
        conv(4'h0, 10'h200, 1'b0, FAST_N, "R8 after second wake invalid", 1'b1);
        frame(4'hD, 10, rd);
        chk("R9 readback 200", 32'(rd), 32'h200);

        repeat (5) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule